// File: doc/BRIEF.md
# Half-Bridge Fault Supervisor and Switch Gating

This block sits between the command register of a multi-channel half-bridge driver and its power stages. It takes the commanded on/off bit of every high-side and low-side switch and combines it with the chip-level protection conditions to produce the final switch enables. Those conditions are undervoltage on the load supply, thermal prewarning and shutdown, hardware and software inhibit, and a per-switch short-circuit mask. It also builds the status bits that the serial interface returns: a sticky power-fail flag, a latched thermal shutdown, an inhibit indication, the prewarning level and one status bit per switch.

All of its logic runs in a single clock domain. The undervoltage qualification window is counted in pulses of a slow time-base strobe, so the delay scales with the strobe rate and not with the clock. Switch enables are registered so that the power stages see clean levels. Status bits are combinational from the registered state and from the current comparator inputs.

Switch numbering is shared with the neighbouring command and status registers. Switch index 2k is the low-side switch of half-bridge k and index 2k+1 is its high-side switch.

Top module: `drv_fault_gate`

## Requirements
- R1: If both switches of one half-bridge (indices 2k and 2k+1) are commanded on in the same cycle, both enables are 0 after the next clock edge. A single commanded switch with no active fault has its enable at 1 after the next clock edge.
- R2: While `hw_inh_n` is 0 or `sw_run` is 0, all enables are 0 from the next clock edge onward and `inh_stat` is 1. When both return to 1, the commanded switches come back on.
- R3: `uv_in` held high for `UV_DLY_TICKS` pulses of `tick` forces all enables to 0 and sets `pwr_fail`. An undervoltage that ends before that many pulses leaves the enables unchanged and `pwr_fail` at 0.
- R4: After a qualified undervoltage, the enables return one clock edge after `uv_in` falls. `pwr_fail` stays 1 until a `stat_clr` pulse arrives while undervoltage is no longer qualified.
- R5: `tsd_in` high at a clock edge sets `tsd_latched` and forces all enables to 0 at that same edge. While the latch is set, `sw_stat`, `pwr_fail`, `inh_stat` and `warn_stat` all read 1.
- R6: A `stat_clr` pulse while `tsd_in` is still 1 does not clear `tsd_latched`. Once `tsd_in` is 0, the latch holds until `stat_clr`, clears at that edge, and the enables return on the edge after.
- R7: Outside thermal shutdown, `warn_stat` equals `tw_warn_in` in every cycle, with no latching, and it has no effect on the enables.
- R8: With `ol_test_n` = 1 and no thermal shutdown, `sw_stat[i]` equals `sw_en[i]`.
- R9: With `ol_test_n` = 0, a switch whose command bit is 0 reports `ol_cmp[i]` in `sw_stat[i]`, and a switch whose command bit is 1 reports its enable.
- R10: `sc_mask[i]` = 1 forces `sw_en[i]` to 0 from the next clock edge and does not affect any other switch.
- R11: After reset, all enables, `pwr_fail`, `tsd_latched` and `sw_stat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe that paces the undervoltage delay |
| uv_in | input | 1 | Load-supply undervoltage comparator, 1 = low supply |
| tw_warn_in | input | 1 | Thermal prewarning comparator (hysteresis applied upstream) |
| tsd_in | input | 1 | Thermal shutdown comparator (hysteresis applied upstream) |
| hw_inh_n | input | 1 | Hardware inhibit pin, 0 = standby |
| sw_run | input | 1 | Software run bit, 0 = standby |
| ol_test_n | input | 1 | Open-load test select, 0 = test active |
| ol_cmp | input | 2*N_BRIDGE | Per-switch open-load comparators |
| cmd_sw | input | 2*N_BRIDGE | Commanded switch bits, 2k = low side, 2k+1 = high side |
| sc_mask | input | 2*N_BRIDGE | Per-switch short-circuit disable |
| stat_clr | input | 1 | One-cycle status reset request |
| sw_en | output | 2*N_BRIDGE | Gated, registered switch enables |
| pwr_fail | output | 1 | Sticky power-fail status |
| tsd_latched | output | 1 | Thermal shutdown latch |
| inh_stat | output | 1 | Standby status |
| warn_stat | output | 1 | Thermal prewarning status |
| sw_stat | output | 2*N_BRIDGE | Per-switch status (readback or open-load result) |

## Verification
A stuck or mis-set fault latch appears at the enables within one clock edge: switches stay dark after a `stat_clr` that should have released them, or come back on while the thermal latch is still reported. A wrong undervoltage count shows up as `pwr_fail` rising on a short dip, or failing to rise after the full window of strobes. A status multiplexer that picks the wrong source is visible in the same cycle on `sw_stat`, once the open-load comparator pattern is chosen to differ from the enable pattern.

// File: rtl/fg_pkg.sv
package fg_pkg;

   typedef enum logic {
      STAT_READBACK = 1'b0,
      STAT_OPENLOAD = 1'b1
   } stat_mode_e;

   // half-bridge interlock: a pair commanded fully on is dropped entirely
   function automatic logic [1:0] pair_gate(input logic lo_cmd, input logic hi_cmd,
                                            input logic lo_blk, input logic hi_blk);
      logic clash;
      clash = lo_cmd & hi_cmd;
      pair_gate = clash ? 2'b00 : {hi_cmd & ~hi_blk, lo_cmd & ~lo_blk};
   endfunction

endpackage

// File: rtl/fg_uv_timer.sv
module fg_uv_timer #(
   parameter int UV_DLY_TICKS = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic uv_in,
   output logic uv_block
);
   localparam int CNT_W = $clog2(UV_DLY_TICKS + 1);
   localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(UV_DLY_TICKS);

   logic [CNT_W-1:0] cnt_q;
   logic             expired;

   assign expired  = (cnt_q == CNT_LIM);
   assign uv_block = uv_in & expired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!uv_in) begin
         cnt_q <= '0;
      end else if (tick && !expired) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/fg_bridge_gate.sv
module fg_bridge_gate
   import fg_pkg::*;
#(
   parameter int N_BRIDGE = 6,
   localparam int N_SW = 2 * N_BRIDGE
) (
   input  logic [N_SW-1:0] cmd_sw,
   input  logic [N_SW-1:0] sc_mask,
   input  logic            global_off,
   output logic [N_SW-1:0] gated
);
   for (genvar k = 0; k < N_BRIDGE; k++) begin : g_pair
      logic [1:0] pg;
      always_comb begin
         pg = pair_gate(cmd_sw[2*k], cmd_sw[2*k+1], sc_mask[2*k], sc_mask[2*k+1]);
         gated[2*k+1:2*k] = global_off ? 2'b00 : pg;
      end
   end
endmodule

// File: rtl/fg_status_mux.sv
module fg_status_mux
   import fg_pkg::*;
#(
   parameter int N_SW = 12
) (
   input  logic [N_SW-1:0] sw_en,
   input  logic [N_SW-1:0] cmd_sw,
   input  logic [N_SW-1:0] ol_cmp,
   input  logic            ol_test_n,
   input  logic            force_hi,
   output logic [N_SW-1:0] sw_stat
);
   for (genvar i = 0; i < N_SW; i++) begin : g_bit
      stat_mode_e mode;
      always_comb begin
         mode = (!ol_test_n && !cmd_sw[i]) ? STAT_OPENLOAD : STAT_READBACK;
         if (force_hi)
            sw_stat[i] = 1'b1;
         else if (mode == STAT_OPENLOAD)
            sw_stat[i] = ol_cmp[i];
         else
            sw_stat[i] = sw_en[i];
      end
   end
endmodule

// File: rtl/drv_fault_gate.sv
module drv_fault_gate #(
   parameter int N_BRIDGE     = 6,
   parameter int UV_DLY_TICKS = 7,
   localparam int N_SW = 2 * N_BRIDGE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            uv_in,
   input  logic            tw_warn_in,
   input  logic            tsd_in,
   input  logic            hw_inh_n,
   input  logic            sw_run,
   input  logic            ol_test_n,
   input  logic [N_SW-1:0] ol_cmp,
   input  logic [N_SW-1:0] cmd_sw,
   input  logic [N_SW-1:0] sc_mask,
   input  logic            stat_clr,
   output logic [N_SW-1:0] sw_en,
   output logic            pwr_fail,
   output logic            tsd_latched,
   output logic            inh_stat,
   output logic            warn_stat,
   output logic [N_SW-1:0] sw_stat
);
   if (N_BRIDGE < 1) begin : g_bad_bridges
      $error("drv_fault_gate: N_BRIDGE must be at least 1");
   end
   if (UV_DLY_TICKS < 1) begin : g_bad_delay
      $error("drv_fault_gate: UV_DLY_TICKS must be at least 1");
   end

   logic            uv_block;
   logic            inhibit;
   logic            global_off;
   logic            pf_q;
   logic            tsd_q;
   logic [N_SW-1:0] gated;
   logic [N_SW-1:0] en_q;

   fg_uv_timer #(.UV_DLY_TICKS(UV_DLY_TICKS)) u_uv (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .uv_in   (uv_in),
      .uv_block(uv_block)
   );

   assign inhibit    = ~hw_inh_n | ~sw_run;
   assign global_off = inhibit | uv_block | tsd_in | tsd_q;

   fg_bridge_gate #(.N_BRIDGE(N_BRIDGE)) u_gate (
      .cmd_sw    (cmd_sw),
      .sc_mask   (sc_mask),
      .global_off(global_off),
      .gated     (gated)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf_q  <= 1'b0;
         tsd_q <= 1'b0;
         en_q  <= '0;
      end else begin
         pf_q  <= uv_block | (pf_q & ~stat_clr);
         tsd_q <= tsd_in | (tsd_q & ~stat_clr);
         en_q  <= gated;
      end
   end

   fg_status_mux #(.N_SW(N_SW)) u_stat (
      .sw_en    (en_q),
      .cmd_sw   (cmd_sw),
      .ol_cmp   (ol_cmp),
      .ol_test_n(ol_test_n),
      .force_hi (tsd_q),
      .sw_stat  (sw_stat)
   );

   assign sw_en       = en_q;
   assign pwr_fail    = pf_q | tsd_q;
   assign tsd_latched = tsd_q;
   assign inh_stat    = inhibit | tsd_q;
   assign warn_stat   = tw_warn_in | tsd_q;
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
   parameter int N_BRIDGE = 6,
   localparam int N_SW = 2 * N_BRIDGE
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tsd_in,
   input logic            hw_inh_n,
   input logic            sw_run,
   input logic            stat_clr,
   input logic [N_SW-1:0] cmd_sw,
   input logic [N_SW-1:0] sc_mask,
   input logic [N_SW-1:0] sw_en,
   input logic            pwr_fail,
   input logic            tsd_latched,
   input logic            inh_stat,
   input logic            warn_stat,
   input logic [N_SW-1:0] sw_stat
);
   for (genvar k = 0; k < N_BRIDGE; k++) begin : g_pair
      p_no_shoot_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_sw[2*k] && cmd_sw[2*k+1]) |=> (!sw_en[2*k] && !sw_en[2*k+1]));
   end

   for (genvar i = 0; i < N_SW; i++) begin : g_sw
      p_mask_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
         sc_mask[i] |=> !sw_en[i]);
   end

   p_inhibit_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_inh_n || !sw_run) |=> (sw_en == '0));

   p_pf_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwr_fail) && !tsd_latched) |-> (sw_en == '0));

   p_pf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_fail && !stat_clr) |=> pwr_fail);

   p_tsd_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tsd_latched |-> ((sw_en == '0) && (&sw_stat) && pwr_fail && inh_stat && warn_stat));

   p_tsd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tsd_in |=> tsd_latched);
endmodule

bind drv_fault_gate fg_checker #(.N_BRIDGE(N_BRIDGE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tsd_in     (tsd_in),
   .hw_inh_n   (hw_inh_n),
   .sw_run     (sw_run),
   .stat_clr   (stat_clr),
   .cmd_sw     (cmd_sw),
   .sc_mask    (sc_mask),
   .sw_en      (sw_en),
   .pwr_fail   (pwr_fail),
   .tsd_latched(tsd_latched),
   .inh_stat   (inh_stat),
   .warn_stat  (warn_stat),
   .sw_stat    (sw_stat)
);

// File: tb/drv_fault_gate_tb.sv
module drv_fault_gate_tb;
   localparam int NB = 6;
   localparam int NS = 2 * NB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          uv_in = 1'b0;
   logic          tw_warn_in = 1'b0;
   logic          tsd_in = 1'b0;
   logic          hw_inh_n = 1'b1;
   logic          sw_run = 1'b1;
   logic          ol_test_n = 1'b1;
   logic [NS-1:0] ol_cmp = '0;
   logic [NS-1:0] cmd_sw = '0;
   logic [NS-1:0] sc_mask = '0;
   logic          stat_clr = 1'b0;
   logic [NS-1:0] sw_en;
   logic          pwr_fail;
   logic          tsd_latched;
   logic          inh_stat;
   logic          warn_stat;
   logic [NS-1:0] sw_stat;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   int tdiv = 0;

   always #5 clk = ~clk;

   // strobe one cycle in four
   always @(negedge clk) begin
      tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
      tick <= (tdiv == 3);
   end

   drv_fault_gate #(.N_BRIDGE(NB), .UV_DLY_TICKS(7)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .uv_in(uv_in),
      .tw_warn_in(tw_warn_in), .tsd_in(tsd_in), .hw_inh_n(hw_inh_n),
      .sw_run(sw_run), .ol_test_n(ol_test_n), .ol_cmp(ol_cmp),
      .cmd_sw(cmd_sw), .sc_mask(sc_mask), .stat_clr(stat_clr),
      .sw_en(sw_en), .pwr_fail(pwr_fail), .tsd_latched(tsd_latched),
      .inh_stat(inh_stat), .warn_stat(warn_stat), .sw_stat(sw_stat)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_clr();
      stat_clr = 1'b1;
      cyc(1);
      stat_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R11 sw_en", 32'(sw_en), 0);
      check("R11 pwr_fail", 32'(pwr_fail), 0);
      check("R11 tsd_latched", 32'(tsd_latched), 0);
      check("R11 sw_stat", 32'(sw_stat), 0);
   endtask

   task automatic t_interlock();
      cmd_sw = 12'b0000_0011_1001; // bridge0 low, bridge1 high, bridge2 both
      cyc(1);
      check("R1 pair clash", 32'(sw_en), 32'h009);
      check("R8 readback", 32'(sw_stat), 32'h009);
      cmd_sw = 12'b0000_0010_0000; // bridge2 high only
      cyc(1);
      check("R1 single on", 32'(sw_en), 32'h020);
   endtask

   task automatic t_mask();
      cmd_sw = 12'h009;
      sc_mask = 12'h008;
      cyc(1);
      check("R10 masked switch", 32'(sw_en), 32'h001);
      sc_mask = '0;
      cyc(1);
      check("R10 unmasked", 32'(sw_en), 32'h009);
   endtask

   task automatic t_inhibit();
      cmd_sw = 12'h009;
      hw_inh_n = 1'b0;
      cyc(1);
      check("R2 hw inhibit en", 32'(sw_en), 0);
      check("R2 hw inhibit stat", 32'(inh_stat), 1);
      hw_inh_n = 1'b1;
      sw_run = 1'b0;
      cyc(1);
      check("R2 sw inhibit en", 32'(sw_en), 0);
      check("R2 sw inhibit stat", 32'(inh_stat), 1);
      sw_run = 1'b1;
      cyc(1);
      check("R2 resume", 32'(sw_en), 32'h009);
      check("R2 stat clear", 32'(inh_stat), 0);
   endtask

   task automatic t_openload();
      cmd_sw = 12'h001;
      ol_cmp = 12'hA50;
      ol_test_n = 1'b0;
      cyc(1);
      check("R9 open-load mix", 32'(sw_stat), 32'hA51);
      ol_cmp = 12'h5A0;
      cyc(1);
      check("R9 open-load follow", 32'(sw_stat), 32'h5A1);
      ol_test_n = 1'b1;
      cyc(1);
      check("R8 readback ignores ol", 32'(sw_stat), 32'h001);
      ol_cmp = '0;
   endtask

   task automatic t_warn();
      cmd_sw = 12'h001;
      tw_warn_in = 1'b1;
      cyc(1);
      check("R7 warn high", 32'(warn_stat), 1);
      check("R7 warn no gating", 32'(sw_en), 32'h001);
      tw_warn_in = 1'b0;
      cyc(1);
      check("R7 warn clears", 32'(warn_stat), 0);
   endtask

   task automatic t_uv_short();
      cmd_sw = 12'h001;
      uv_in = 1'b1;
      cyc(10);
      check("R3 short dip en", 32'(sw_en), 32'h001);
      uv_in = 1'b0;
      cyc(2);
      check("R3 short dip pf", 32'(pwr_fail), 0);
      check("R3 short dip after", 32'(sw_en), 32'h001);
   endtask

   task automatic t_uv_long();
      cmd_sw = 12'h001;
      uv_in = 1'b1;
      cyc(40);
      check("R3 uv off", 32'(sw_en), 0);
      check("R3 uv pf", 32'(pwr_fail), 1);
      uv_in = 1'b0;
      cyc(1);
      check("R4 uv release", 32'(sw_en), 32'h001);
      cyc(5);
      check("R4 pf sticky", 32'(pwr_fail), 1);
      pulse_clr();
      check("R4 pf cleared", 32'(pwr_fail), 0);
   endtask

   task automatic t_tsd();
      cmd_sw = 12'h001;
      ol_test_n = 1'b1;
      tsd_in = 1'b1;
      cyc(1);
      check("R5 latch", 32'(tsd_latched), 1);
      check("R5 off", 32'(sw_en), 0);
      check("R5 stat all high", 32'(sw_stat), 32'hFFF);
      check("R5 flags high", 32'({pwr_fail, inh_stat, warn_stat}), 32'h7);
      pulse_clr();
      check("R6 clear blocked", 32'(tsd_latched), 1);
      tsd_in = 1'b0;
      cyc(3);
      check("R6 hold cool", 32'(tsd_latched), 1);
      check("R6 still off", 32'(sw_en), 0);
      pulse_clr();
      check("R6 cleared", 32'(tsd_latched), 0);
      cyc(1);
      check("R6 resume", 32'(sw_en), 32'h001);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_interlock();
      t_mask();
      t_inhibit();
      t_openload();
      t_warn();
      t_uv_short();
      t_uv_long();
      t_tsd();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule